// File: doc/BRIEF.md
# Grouped Prioritized Interrupt Controller

This block gathers a bank of maskable interrupt lines, divides them into fixed groups of equal size, and adds one non-maskable request line. Every clock it copies the lines into per-group request registers, which software reads to learn which line inside a group fired. All lines of a group are ORed into a single group-pending signal. Choosing between lines inside one group is left to software.

Each group has a priority register that holds a two-bit level (0 to 3) and a 14-bit handler offset. A pending group is qualified when the processor's mask bit for its level is clear and the global mask is clear. The qualified group with the highest level wins. A level tie goes to the lowest-numbered group. The winner's level and offset are registered and presented as the autovector. The non-maskable request beats every other request and ignores all masks. A small register bus writes and reads the priority registers and reads the request registers. The block keeps running while the processor is halted for debug. If its clock is gated off, it holds its state and continues once the clock returns.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A read at a request-register address (addr_i[3]=1, group index in addr_i[2:0]) returns in rdata_o[7:0] the lines of that group as sampled at the latest clock edge. Line g*8+i appears at bit i. Bits 31:8 read as zero.
- R2: A group is pending when any of its eight lines is high. The position of the line inside the group does not change the outcome.
- R3: A write at a priority address (addr_i[3]=0) sets the group's level from wdata_i[31:30] and its offset from wdata_i[13:0]. A read at the same address returns the level in bits 31:30 and the offset in bits 13:0.
- R4: A pending group is ignored when lvl_mask_i bit (its level) is 1. When glob_mask_i is 1, every maskable group is ignored.
- R5: Among the qualified groups, the group with the highest level wins, and its level and offset drive level_o and offset_o.
- R6: When qualified groups share the highest level, the group with the lowest index wins.
- R7: When nmi_i is high, the next outputs are req_o=1, nmi_o=1, level_o=0 and offset_o=0, whatever the masks and the other lines are.
- R8: The outputs are registered and follow the inputs sampled at the previous clock edge. When nothing qualifies, req_o, nmi_o, level_o and offset_o are all 0.
- R9: Writes to request-register addresses have no effect. Bits 29:14 of a priority read are always zero.
- R10: After reset, all outputs are 0 and every priority register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Maskable interrupt lines |
| nmi_i | input | 1 | Non-maskable request |
| lvl_mask_i | input | 4 | Per-level mask from the processor status register, 1 = masked |
| glob_mask_i | input | 1 | Global interrupt mask, 1 = masked |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address: bit 3 selects request (1) or priority (0), bits 2:0 select the group |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| req_o | output | 1 | Interrupt request to the processor |
| nmi_o | output | 1 | The current request is the non-maskable one |
| level_o | output | 2 | Level of the winning group |
| offset_o | output | 14 | Handler offset of the winning group |

## Verification
The assertions check, on every cycle, the properties that need no knowledge of the programmed levels. The request registers must equal the previous cycle's lines. NMI must always win. An idle or globally masked input must give no request. A granted maskable level must not be masked, and idle outputs must be zero. Only the bench's scenarios can show that the winner is the highest level, that a tie goes to the lowest group, that the right offset is delivered, and that priority and request registers read back correctly. For this the bench's reference model tracks the programmed priorities.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int OFF_W   = 14;
  localparam int DATA_W  = 32;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [OFF_W-1:0] off;
  } prio_t;
endpackage

// File: rtl/grp_irq_prio.sv
module grp_irq_prio
  import grp_irq_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int IDX_W   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output prio_t [NUM_GRP-1:0]  prio_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[g] <= '0;
      end else if (we_i && (int'(idx_i) == g)) begin
        prio_o[g].lvl <= wdata_i[DATA_W-1 -: LVL_W];
        prio_o[g].off <= wdata_i[OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/grp_irq_sample.sv
module grp_irq_sample #(
  parameter int NUM_LINES = 64,
  parameter int GRP_W     = 8,
  localparam int NUM_GRP  = NUM_LINES / GRP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic [NUM_LINES-1:0] irr_o,
  output logic [NUM_GRP-1:0]   pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irr_o <= '0;
    else         irr_o <= irq_i;
  end

  // pending taken from the live lines so the vector lands in the same edge as the sample
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_or
    assign pend_o[g] = |irq_i[g*GRP_W +: GRP_W];
  end
endmodule

// File: rtl/grp_irq_arb.sv
module grp_irq_arb
  import grp_irq_pkg::*;
#(
  parameter int NUM_GRP = 8
) (
  input  logic [NUM_GRP-1:0]  pend_i,
  input  prio_t [NUM_GRP-1:0] prio_i,
  input  logic [NUM_LVL-1:0]  lvl_mask_i,
  input  logic                glob_mask_i,
  input  logic                nmi_i,
  output logic                req_o,
  output logic                nmi_o,
  output logic [LVL_W-1:0]    lvl_o,
  output logic [OFF_W-1:0]    off_o
);
  logic [NUM_GRP-1:0] valid;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_val
    assign valid[g] = pend_i[g] & ~glob_mask_i & ~lvl_mask_i[prio_i[g].lvl];
  end

  always_comb begin
    logic             found;
    logic [LVL_W-1:0] best_lvl;
    logic [OFF_W-1:0] best_off;
    found    = 1'b0;
    best_lvl = '0;
    best_off = '0;
    // ascending scan with strict compare: lowest index keeps a tie
    for (int g = 0; g < NUM_GRP; g++) begin
      if (valid[g] && (!found || prio_i[g].lvl > best_lvl)) begin
        found    = 1'b1;
        best_lvl = prio_i[g].lvl;
        best_off = prio_i[g].off;
      end
    end
    req_o = nmi_i | found;
    nmi_o = nmi_i;
    lvl_o = nmi_i ? '0 : best_lvl;
    off_o = nmi_i ? '0 : best_off;
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int GRP_W     = 8,
  localparam int NUM_GRP  = NUM_LINES / GRP_W,
  localparam int IDX_W    = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int ADDR_W   = IDX_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 nmi_i,
  input  logic [NUM_LVL-1:0]   lvl_mask_i,
  input  logic                 glob_mask_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 req_o,
  output logic                 nmi_o,
  output logic [LVL_W-1:0]     level_o,
  output logic [OFF_W-1:0]     offset_o
);
  logic                 sel_irr;
  logic [IDX_W-1:0]     idx;
  logic [NUM_LINES-1:0] irr_q;
  logic [NUM_GRP-1:0]   pend;
  prio_t [NUM_GRP-1:0]  prio;
  logic                 a_req, a_nmi;
  logic [LVL_W-1:0]     a_lvl;
  logic [OFF_W-1:0]     a_off;

  assign sel_irr = addr_i[ADDR_W-1];
  assign idx     = addr_i[IDX_W-1:0];

  grp_irq_prio #(.NUM_GRP(NUM_GRP), .IDX_W(IDX_W)) u_prio (
    .clk_i, .rst_ni,
    .we_i   (wr_en_i & ~sel_irr),
    .idx_i  (idx),
    .wdata_i,
    .prio_o (prio)
  );

  grp_irq_sample #(.NUM_LINES(NUM_LINES), .GRP_W(GRP_W)) u_smp (
    .clk_i, .rst_ni, .irq_i,
    .irr_o  (irr_q),
    .pend_o (pend)
  );

  grp_irq_arb #(.NUM_GRP(NUM_GRP)) u_arb (
    .pend_i (pend), .prio_i (prio),
    .lvl_mask_i, .glob_mask_i, .nmi_i,
    .req_o (a_req), .nmi_o (a_nmi), .lvl_o (a_lvl), .off_o (a_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o    <= 1'b0;
      nmi_o    <= 1'b0;
      level_o  <= '0;
      offset_o <= '0;
    end else begin
      req_o    <= a_req;
      nmi_o    <= a_nmi;
      level_o  <= a_lvl;
      offset_o <= a_off;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(idx) < NUM_GRP) begin
      if (sel_irr) begin
        rdata_o[GRP_W-1:0] = irr_q[idx*GRP_W +: GRP_W];
      end else begin
        rdata_o[DATA_W-1 -: LVL_W] = prio[idx].lvl;
        rdata_o[OFF_W-1:0]         = prio[idx].off;
      end
    end
  end
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk
  import grp_irq_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] irq_i,
  input logic                 nmi_i,
  input logic [NUM_LVL-1:0]   lvl_mask_i,
  input logic                 glob_mask_i,
  input logic                 req_o,
  input logic                 nmi_o,
  input logic [LVL_W-1:0]     level_o,
  input logic [OFF_W-1:0]     offset_o,
  input logic [NUM_LINES-1:0] irr
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  p_irr_sample_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> irr == $past(irq_i));

  p_nmi_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(nmi_i) |-> req_o && nmi_o && level_o == '0 && offset_o == '0);

  p_glob_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(glob_mask_i) && !$past(nmi_i) |-> !req_o);

  p_lvl_unmasked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && req_o && !nmi_o |-> ($past(lvl_mask_i) & (4'b1 << level_o)) == 4'b0);

  p_idle_no_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(irq_i) == '0 && !$past(nmi_i) |-> !req_o);

  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> !nmi_o && level_o == '0 && offset_o == '0);
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i, .rst_ni, .irq_i, .nmi_i, .lvl_mask_i, .glob_mask_i,
  .req_o, .nmi_o, .level_o, .offset_o, .irr(irr_q)
);

// File: tb/grp_irq_ctrl_bench.sv
module grp_irq_ctrl_bench;
  localparam int NL = 64;
  localparam int GW = 8;
  localparam int NG = NL / GW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        nmi = 1'b0;
  logic [3:0]  lmask = '0;
  logic        gmask = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req, nmi_out;
  logic [1:0]  lvl;
  logic [13:0] off;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R10";

  // reference model state
  int          m_lvl[NG];
  int          m_off[NG];
  logic [63:0] m_irr = '0;
  logic        e_req = 0, e_nmi = 0;
  int          e_lvl = 0, e_off = 0;

  always #5 clk = ~clk;

  grp_irq_ctrl u_grp_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi), .lvl_mask_i(lmask),
    .glob_mask_i(gmask), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .req_o(req), .nmi_o(nmi_out), .level_o(lvl), .offset_o(off)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin m_lvl[g] = 0; m_off[g] = 0; end
      m_irr = '0; e_req = 0; e_nmi = 0; e_lvl = 0; e_off = 0;
    end else begin
      int best;
      best = -1;
      for (int g = 0; g < NG; g++) begin
        if ((|irq[g*GW +: GW]) && !gmask && !lmask[m_lvl[g]] &&
            (best < 0 || m_lvl[g] > m_lvl[best])) best = g;
      end
      if (nmi) begin
        e_req = 1; e_nmi = 1; e_lvl = 0; e_off = 0;
      end else if (best >= 0) begin
        e_req = 1; e_nmi = 0; e_lvl = m_lvl[best]; e_off = m_off[best];
      end else begin
        e_req = 0; e_nmi = 0; e_lvl = 0; e_off = 0;
      end
      m_irr = irq;
      if (wr_en && !addr[3]) begin
        m_lvl[addr[2:0]] = int'(wdata[31:30]);
        m_off[addr[2:0]] = int'(wdata[13:0]);
      end
    end
  end

  task automatic chk_out();
    n_chk++;
    if (req !== e_req || nmi_out !== e_nmi || int'(lvl) != e_lvl || int'(off) != e_off) begin
      n_fail++;
      $display("FAIL %s: req/nmi/lvl/off got %0b/%0b/%0d/%0h exp %0b/%0b/%0d/%0h",
               tag, req, nmi_out, lvl, off, e_req, e_nmi, e_lvl, e_off);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk_out();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string t);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata @%0h got %0h exp %0h", t, a, rdata, exp);
    end
  endtask

  function automatic logic [31:0] prio_word(int g);
    logic [31:0] w;
    w = '0;
    w[31:30] = 2'(m_lvl[g]);
    w[13:0]  = 14'(m_off[g]);
    return w;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    tag = "R10";
    chk_out();
    rst_n = 1;
    step();
    for (int g = 0; g < NG; g++) rd(4'(g), 32'h0, "R10");

    // R3 / R9: program levels, junk in unused bits
    tag = "R3";
    wr(4'd0, 32'h7fff_c100);  // lvl1 off 0x0100
    wr(4'd1, 32'h4000_0200);  // lvl1
    wr(4'd2, 32'hc000_3fff);  // lvl3
    wr(4'd3, 32'h8000_0333);  // lvl2
    wr(4'd4, 32'hc000_0044);  // lvl3
    wr(4'd5, 32'h0000_0055);  // lvl0
    for (int g = 0; g < 6; g++) rd(4'(g), prio_word(g), "R3/R9");

    // R2: top line of group 2
    tag = "R2"; irq = 64'h0000_0000_0080_0000; step();
    tag = "R8"; irq = '0; step();
    // R6: groups 0 and 1 both level 1
    tag = "R6"; irq = 64'h0000_0000_0000_0101; step();
    // R5: group 3 (lvl2) beats group 0 (lvl1)
    tag = "R5"; irq = 64'h0000_0000_1000_0001; step();
    // R6: groups 4 and 2 both level 3 -> group 2
    tag = "R6"; irq = 64'h0000_0001_0001_0000; step();
    // R4: mask level 3 -> falls back to group 3
    tag = "R4"; irq = 64'h0000_0001_0101_0000; lmask = 4'b1000; step();
    lmask = 4'b1100; step();
    lmask = 4'b0000; gmask = 1; step();
    // R7: NMI under global mask
    tag = "R7"; nmi = 1; step();
    gmask = 0; lmask = 4'hf; step();
    nmi = 0; lmask = 0;
    // R1: request register readback
    tag = "R1"; irq = 64'ha5c3_0000_9600_1281; step();
    for (int g = 0; g < NG; g++) rd(4'(8 + g), {24'h0, m_irr[g*GW +: GW]}, "R1");
    // R9: write to request register ignored
    tag = "R9"; wr(4'd9, 32'hffff_ffff);
    rd(4'd9, {24'h0, m_irr[15:8]}, "R9");
    rd(4'd1, prio_word(1), "R9");
    // R8: release everything, idle in one cycle
    tag = "R8"; irq = '0; step(); step();

    // mixed traffic
    tag = "R5";
    for (int i = 0; i < 400; i++) begin
      irq   = {$urandom, $urandom} & {$urandom, $urandom};
      nmi   = ($urandom % 16) == 0;
      lmask = 4'($urandom);
      gmask = ($urandom % 8) == 0;
      if (($urandom % 6) == 0) begin
        wr_en = 1; addr = 4'($urandom % 16); wdata = $urandom;
      end
      step();
      wr_en = 0;
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule